// File: doc/BRIEF.md
# Ferroelectric Row Refresh and Access Sequencer

This block sequences row operations for one array of single-transistor ferroelectric cells. It runs three kinds of row operation: a refresh, a plain read and a plain write. Each operation is made of up to three phases. The sense phase reads the row into a row register. The clear phase drives the columns that hold 0 to the negative polarity. The set phase drives the columns that hold 1 to the positive polarity. While a phase is active, the block drives a symbolic 3-bit bias code onto every word line, every write bit line and every read bit line. The analog drivers turn these codes into voltages.

A read does not disturb the cells, so a plain read is only the sense phase. A write loads the row register from the request data and runs the clear and set phases. A refresh runs all three phases on the row named by an internal refresh counter, and the counter then advances. Refresh requests can be gated off, for example while the part is powered down, and the counter keeps its position until refresh is enabled again. The length of each phase in clock cycles comes from an input.

Top module: `fe_row_seq`

## Requirements
- R1: A refresh runs sense, then clear, then set. Each phase lasts the number of cycles on its length input, and a length of 0 counts as 1. The sensed data is written back and can be read on rd_bits afterwards.
- R2: A read runs only the sense phase. When it completes, rd_bits holds the sense_bits value that was present at the end of that phase.
- R3: A write runs clear and then set, and uses the wr_bits value captured in the cycle the request is accepted.
- R4: In the sense phase, the selected word line is 001 (+2/3 Vc), every read bit line is 011 (sense level) and every write bit line is 000 (ground).
- R5: In the clear phase, the selected word line is 001. The write bit line of each column holding 0 is 010 (-2/3 Vc), the write bit line of each column holding 1 is 000, and every read bit line is 100 (float).
- R6: In the set phase, the selected word line is 010. The write bit line of each column holding 1 is 001, the write bit line of each column holding 0 is 000, and every read bit line is 100.
- R7: Unselected word lines are always 000. When idle, every line is 000. Only the codes 000 to 100 ever appear.
- R8: busy is high from the cycle after a request is accepted until the last phase ends. done pulses for the first idle cycle after an operation. Requests made while busy are ignored.
- R9: When several requests arrive together while idle, refresh wins over write, and write wins over read.
- R10: The refresh counter is 0 after reset. A refresh uses the counter's row, and the counter steps by one after each refresh, wrapping from ROWS-1 to 0.
- R11: While refresh_en is low, refresh_req is ignored and the counter holds. When refresh_en is high again, refresh continues from the held row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Plain read request |
| wr_req | input | 1 | Plain write request |
| acc_row | input | RW | Row for read or write |
| wr_bits | input | COLS | Write data |
| refresh_req | input | 1 | Refresh request |
| refresh_en | input | 1 | Refresh enable |
| sense_bits | input | COLS | Sense amplifier result, one bit per column |
| len_sense | input | PW | Sense phase length in cycles |
| len_wr0 | input | PW | Clear phase length in cycles |
| len_wr1 | input | PW | Set phase length in cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_bits | output | COLS | Row register contents |
| refresh_row | output | RW | Next row to refresh |
| wl_bias | output | ROWS*3 | Word line bias codes, row r at bits 3r+2:3r |
| wbl_bias | output | COLS*3 | Write bit line bias codes, column c at bits 3c+2:3c |
| rbl_bias | output | COLS*3 | Read bit line bias codes, column c at bits 3c+2:3c |

## Verification
The assertions assume that a request can only take effect from the idle state. They also assume that the refresh counter changes only when a refresh ends, so any change of the counter must coincide with the done pulse. The bench starts every operation on an idle cycle, holds the length inputs and sense_bits constant for the whole operation, and deliberately raises extra requests only while busy, to show that they are dropped. Sweeps cover every row for reads, every data pattern for writes and refreshes, and enough refreshes to wrap the counter.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;
    typedef enum logic [2:0] {
        BIAS_GND = 3'b000,
        BIAS_POS = 3'b001,
        BIAS_NEG = 3'b010,
        BIAS_SNS = 3'b011,
        BIAS_FLT = 3'b100
    } bias_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SENSE,
        PH_WR0,
        PH_WR1
    } phase_e;

    typedef enum logic [1:0] {
        OP_RD,
        OP_WR,
        OP_REF
    } op_e;
endpackage

// File: rtl/fe_seq_phase.sv
module fe_seq_phase
    import fe_seq_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          ref_go,
    input  logic [PW-1:0] len_sense,
    input  logic [PW-1:0] len_wr0,
    input  logic [PW-1:0] len_wr1,
    output phase_e        phase,
    output logic          start,
    output op_e           start_op,
    output logic          sense_end,
    output logic          ref_end,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        phase_e        phase;
        op_e           op;
        logic [PW-1:0] timer;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Timer load value: a length of 0 counts as a single cycle.
    function automatic logic [PW-1:0] ld(input logic [PW-1:0] l);
        return (l == '0) ? '0 : l - PW'(1);
    endfunction

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        start     = 1'b0;
        start_op  = OP_RD;
        sense_end = 1'b0;
        ref_end   = 1'b0;
        if (ctl_q.phase == PH_IDLE) begin
            if (ref_go) begin
                start       = 1'b1;
                start_op    = OP_REF;
                ctl_d.op    = OP_REF;
                ctl_d.phase = PH_SENSE;
                ctl_d.timer = ld(len_sense);
            end else if (wr_req) begin
                start       = 1'b1;
                start_op    = OP_WR;
                ctl_d.op    = OP_WR;
                ctl_d.phase = PH_WR0;
                ctl_d.timer = ld(len_wr0);
            end else if (rd_req) begin
                start       = 1'b1;
                start_op    = OP_RD;
                ctl_d.op    = OP_RD;
                ctl_d.phase = PH_SENSE;
                ctl_d.timer = ld(len_sense);
            end
        end else if (ctl_q.timer != '0) begin
            ctl_d.timer = ctl_q.timer - PW'(1);
        end else begin
            unique case (ctl_q.phase)
                PH_SENSE: begin
                    sense_end = 1'b1;
                    if (ctl_q.op == OP_RD) begin
                        ctl_d.phase = PH_IDLE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.phase = PH_WR0;
                        ctl_d.timer = ld(len_wr0);
                    end
                end
                PH_WR0: begin
                    ctl_d.phase = PH_WR1;
                    ctl_d.timer = ld(len_wr1);
                end
                default: begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.done  = 1'b1;
                    ref_end     = (ctl_q.op == OP_REF);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, op: OP_RD, timer: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase = ctl_q.phase;
    assign busy  = (ctl_q.phase != PH_IDLE);
    assign done  = ctl_q.done;
endmodule

// File: rtl/fe_seq_bias.sv
module fe_seq_bias
    import fe_seq_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int RW   = 3
) (
    input  phase_e            phase,
    input  logic [RW-1:0]     row,
    input  logic [COLS-1:0]   data,
    output logic [ROWS*3-1:0] wl_bias,
    output logic [COLS*3-1:0] wbl_bias,
    output logic [COLS*3-1:0] rbl_bias
);
    bias_e wl_sel;
    bias_e rbl_all;

    always_comb begin
        unique case (phase)
            PH_SENSE: begin wl_sel = BIAS_POS; rbl_all = BIAS_SNS; end
            PH_WR0:   begin wl_sel = BIAS_POS; rbl_all = BIAS_FLT; end
            PH_WR1:   begin wl_sel = BIAS_NEG; rbl_all = BIAS_FLT; end
            default:  begin wl_sel = BIAS_GND; rbl_all = BIAS_GND; end
        endcase
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        assign wl_bias[3*r +: 3] = (row == RW'(r)) ? wl_sel : BIAS_GND;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        bias_e wbl_c;
        always_comb begin
            if (phase == PH_WR0 && !data[c]) begin
                wbl_c = BIAS_NEG;
            end else if (phase == PH_WR1 && data[c]) begin
                wbl_c = BIAS_POS;
            end else begin
                wbl_c = BIAS_GND;
            end
        end
        assign wbl_bias[3*c +: 3] = wbl_c;
        assign rbl_bias[3*c +: 3] = rbl_all;
    end
endmodule

// File: rtl/fe_seq_refctr.sv
module fe_seq_refctr #(
    parameter int ROWS = 8,
    parameter int RW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [RW-1:0] row
);
    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            cnt_d = (cnt_q == RW'(ROWS - 1)) ? '0 : cnt_q + RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign row = cnt_q;
endmodule

// File: rtl/fe_row_seq.sv
module fe_row_seq
    import fe_seq_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int PW   = 4,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [RW-1:0]     acc_row,
    input  logic [COLS-1:0]   wr_bits,
    input  logic              refresh_req,
    input  logic              refresh_en,
    input  logic [COLS-1:0]   sense_bits,
    input  logic [PW-1:0]     len_sense,
    input  logic [PW-1:0]     len_wr0,
    input  logic [PW-1:0]     len_wr1,
    output logic              busy,
    output logic              done,
    output logic [COLS-1:0]   rd_bits,
    output logic [RW-1:0]     refresh_row,
    output logic [ROWS*3-1:0] wl_bias,
    output logic [COLS*3-1:0] wbl_bias,
    output logic [COLS*3-1:0] rbl_bias
);
    typedef struct packed {
        logic [RW-1:0]   row;
        logic [COLS-1:0] data;
    } rowreg_t;

    rowreg_t rr_d, rr_q;
    phase_e  phase;
    op_e     start_op;
    logic    start, sense_end, ref_end;

    fe_seq_phase #(.PW(PW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .ref_go    (refresh_req && refresh_en),
        .len_sense (len_sense),
        .len_wr0   (len_wr0),
        .len_wr1   (len_wr1),
        .phase     (phase),
        .start     (start),
        .start_op  (start_op),
        .sense_end (sense_end),
        .ref_end   (ref_end),
        .busy      (busy),
        .done      (done)
    );

    fe_seq_refctr #(.ROWS(ROWS), .RW(RW)) u_refctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ref_end),
        .row   (refresh_row)
    );

    always_comb begin
        rr_d = rr_q;
        if (start) begin
            rr_d.row = (start_op == OP_REF) ? refresh_row : acc_row;
            if (start_op == OP_WR) begin
                rr_d.data = wr_bits;
            end
        end
        if (sense_end) begin
            rr_d.data = sense_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end

    fe_seq_bias #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_bias (
        .phase    (phase),
        .row      (rr_q.row),
        .data     (rr_q.data),
        .wl_bias  (wl_bias),
        .wbl_bias (wbl_bias),
        .rbl_bias (rbl_bias)
    );

    assign rd_bits = rr_q.data;
endmodule

// File: rtl/fe_row_seq_chk.sv
module fe_row_seq_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int RW   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [RW-1:0]     refresh_row,
    input logic [ROWS*3-1:0] wl_bias,
    input logic [COLS*3-1:0] wbl_bias,
    input logic [COLS*3-1:0] rbl_bias
);
    logic legal, all_gnd, any_sns, wbl_gnd;
    int   wl_cnt;

    always_comb begin
        legal   = 1'b1;
        any_sns = 1'b0;
        wl_cnt  = 0;
        for (int i = 0; i < ROWS; i++) begin
            if (wl_bias[3*i +: 3] > 3'd4) legal = 1'b0;
            if (wl_bias[3*i +: 3] != 3'd0) wl_cnt = wl_cnt + 1;
        end
        for (int i = 0; i < COLS; i++) begin
            if (wbl_bias[3*i +: 3] > 3'd4) legal = 1'b0;
            if (rbl_bias[3*i +: 3] > 3'd4) legal = 1'b0;
            if (rbl_bias[3*i +: 3] == 3'd3) any_sns = 1'b1;
        end
        wbl_gnd = (wbl_bias == '0);
        all_gnd = (wl_bias == '0) && wbl_gnd && (rbl_bias == '0);
    end

    // R7
    codes_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) legal);
    // R7
    one_wl_chk: assert property (@(posedge clk) disable iff (!rst_n) wl_cnt <= 1);
    // R7
    idle_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> all_gnd);
    // R4
    sense_wbl_chk: assert property (@(posedge clk) disable iff (!rst_n) any_sns |-> wbl_gnd);
    // R8
    done_fell_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
    // R10
    ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_row != $past(refresh_row)) |-> done);
endmodule

bind fe_row_seq fe_row_seq_chk #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .refresh_row (refresh_row),
    .wl_bias     (wl_bias),
    .wbl_bias    (wbl_bias),
    .rbl_bias    (rbl_bias)
);

// File: tb/fe_row_seq_bench.sv
module fe_row_seq_bench;
    localparam int ROWS = 8;
    localparam int COLS = 4;
    localparam int PW   = 4;
    localparam int RW   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0, wr_req = 1'b0, refresh_req = 1'b0, refresh_en = 1'b1;
    logic [RW-1:0]     acc_row = '0;
    logic [COLS-1:0]   wr_bits = '0, sense_bits = '0;
    logic [PW-1:0]     len_sense = 4'd1, len_wr0 = 4'd1, len_wr1 = 4'd1;
    logic              busy, done;
    logic [COLS-1:0]   rd_bits;
    logic [RW-1:0]     refresh_row;
    logic [ROWS*3-1:0] wl_bias;
    logic [COLS*3-1:0] wbl_bias, rbl_bias;

    int checks = 0;
    int errors = 0;
    int exp_ref = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fe_row_seq #(.ROWS(ROWS), .COLS(COLS), .PW(PW)) u_fe_row_seq (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .acc_row(acc_row),
        .wr_bits(wr_bits), .refresh_req(refresh_req), .refresh_en(refresh_en),
        .sense_bits(sense_bits), .len_sense(len_sense), .len_wr0(len_wr0), .len_wr1(len_wr1),
        .busy(busy), .done(done), .rd_bits(rd_bits), .refresh_row(refresh_row),
        .wl_bias(wl_bias), .wbl_bias(wbl_bias), .rbl_bias(rbl_bias)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // phase: 0 idle, 1 sense, 2 clear, 3 set
    function automatic logic [ROWS*3-1:0] e_wl(input int ph, input int row);
        logic [ROWS*3-1:0] v = '0;
        for (int r = 0; r < ROWS; r++)
            if (r == row && ph != 0) v[3*r +: 3] = (ph == 3) ? 3'd2 : 3'd1;
        return v;
    endfunction

    function automatic logic [COLS*3-1:0] e_wbl(input int ph, input logic [COLS-1:0] d);
        logic [COLS*3-1:0] v = '0;
        for (int c = 0; c < COLS; c++) begin
            if (ph == 2 && !d[c]) v[3*c +: 3] = 3'd2;
            if (ph == 3 && d[c])  v[3*c +: 3] = 3'd1;
        end
        return v;
    endfunction

    function automatic logic [COLS*3-1:0] e_rbl(input int ph);
        logic [COLS*3-1:0] v = '0;
        for (int c = 0; c < COLS; c++)
            v[3*c +: 3] = (ph == 1) ? 3'd3 : (ph >= 2) ? 3'd4 : 3'd0;
        return v;
    endfunction

    function automatic int eff(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    // op: 0 read, 1 write, 2 refresh. Called at a negedge with the block idle.
    task automatic run_op(input logic q_rd, input logic q_wr, input logic q_ref, input int op,
                          input int row, input logic [COLS-1:0] wd, input logic [COLS-1:0] sd,
                          input int ls, input int l0, input int l1, input bit poke);
        int ph_first, ph_last, r;
        logic [COLS-1:0] d;
        string tag;
        ph_first = (op == 1) ? 2 : 1;
        ph_last  = (op == 0) ? 1 : 3;
        r   = (op == 2) ? exp_ref : row;
        d   = (op == 1) ? wd : sd;
        tag = (op == 0) ? "R2" : (op == 1) ? "R3" : "R1";
        rd_req = q_rd; wr_req = q_wr; refresh_req = q_ref;
        acc_row = RW'(row); wr_bits = wd; sense_bits = sd;
        len_sense = PW'(ls); len_wr0 = PW'(l0); len_wr1 = PW'(l1);
        for (int ph = ph_first; ph <= ph_last; ph++) begin
            int len;
            len = eff((ph == 1) ? ls : (ph == 2) ? l0 : l1);
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                rd_req = 1'b0; wr_req = 1'b0; refresh_req = 1'b0;
                if (poke && ph == ph_first && k == 0) begin
                    rd_req = 1'b1; wr_req = 1'b1; refresh_req = 1'b1; // R8 held off
                end
                check("R8 busy", busy, 1);
                if (ph == 1) begin
                    check("R4 wl", wl_bias, e_wl(ph, r));
                    check("R4 wbl", wbl_bias, e_wbl(ph, d));
                    check("R4 rbl", rbl_bias, e_rbl(ph));
                end else if (ph == 2) begin
                    check("R5 wl", wl_bias, e_wl(ph, r));
                    check("R5 wbl", wbl_bias, e_wbl(ph, d));
                    check("R5 rbl", rbl_bias, e_rbl(ph));
                end else begin
                    check("R6 wl", wl_bias, e_wl(ph, r));
                    check("R6 wbl", wbl_bias, e_wbl(ph, d));
                    check("R6 rbl", rbl_bias, e_rbl(ph));
                end
            end
        end
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0; refresh_req = 1'b0;
        check("R8 busy end", busy, 0);
        check("R8 done", done, 1);
        check({tag, " rd_bits"}, rd_bits, d);
        check("R7 idle wl", wl_bias, '0);
        if (op == 2) exp_ref = (exp_ref + 1) % ROWS;
        check("R10 refresh_row", refresh_row, exp_ref);
        if (poke) begin
            @(negedge clk);
            check("R8 no restart", busy, 0);
            check("R8 done pulse", done, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset busy", busy, 0);
        check("R7 reset wl", wl_bias, '0);
        check("R7 reset wbl", wbl_bias, '0);
        check("R7 reset rbl", rbl_bias, '0);
        check("R10 reset row", refresh_row, 0);
        check("R8 reset done", done, 0);
        // R2 reads on every row
        for (int r = 0; r < ROWS; r++)
            run_op(1, 0, 0, 0, r, '0, COLS'(r * 5 + 3), r % 3, 0, 0, 0);
        // R3 writes of every pattern, R1 length of 0 counts as 1
        for (int p = 0; p < (1 << COLS); p++)
            run_op(0, 1, 0, 1, p % ROWS, COLS'(p), '0, 0, p % 4, (p + 1) % 3, 0);
        // R1 R10 refreshes wrapping the counter
        for (int i = 0; i < ROWS + 3; i++)
            run_op(0, 0, 1, 2, 0, '0, COLS'(i * 7), 1 + i % 2, i % 3, 2, 0);
        // R9 priority
        run_op(1, 1, 1, 2, 5, 4'hA, 4'h6, 1, 1, 1, 0);
        run_op(1, 1, 0, 1, 5, 4'hA, 4'h6, 1, 1, 1, 0);
        // R8 requests while busy dropped
        run_op(1, 0, 0, 0, 2, '0, 4'h9, 2, 1, 1, 1);
        run_op(0, 1, 0, 1, 3, 4'h5, '0, 1, 2, 1, 1);
        // R11 refresh disabled
        refresh_en = 1'b0;
        refresh_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
        check("R11 gated busy", busy, 0);
        @(negedge clk);
        check("R11 counter held", refresh_row, exp_ref);
        run_op(1, 0, 0, 0, 1, '0, 4'h3, 1, 1, 1, 0);
        check("R11 counter held after read", refresh_row, exp_ref);
        refresh_en = 1'b1;
        run_op(0, 0, 1, 2, 0, '0, 4'hC, 1, 1, 1, 0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule